// File: doc/BRIEF.md
# Queued SPI Master

This block is a full-duplex SPI master that works through a list of transfers held in on-block queue memory, with no processor involvement between entries. Every queue entry pairs a transmit word with a command word. The command picks the pattern driven on four peripheral-select outputs and can hold that pattern across into the next transfer. The word received during entry *i* is written to slot *i* of a receive memory, where software reads it back through a separate read port.

Software sets up the transfer list, the baud divider, the first and last entry and the idle select pattern through one write port, and then writes the go bit. The sequencer steps from the first entry to the last. The index wraps from 31 to 0, so the list can straddle the top of the queue. When the last entry has finished, the sequencer raises a sticky completion flag that doubles as the interrupt request.

In wrap mode the sequencer returns to the first entry after the last one and keeps going. A serial ADC can be sampled this way without pause, and the flag is set again on every pass. Writing the go bit as zero stops the queue cleanly at an entry boundary.

Top module: `qspi_master`

## Requirements
- R1: After reset `sclk` is 0, `pcs` is 4'hF (the reset idle pattern), `busy` is 0 and `done_irq` is 0.
- R2: Each transfer is 16 bits long and sent MSB first. `sclk` idles low. `mosi` changes only after a falling edge. `miso` is sampled on every rising edge, so the word shifted out and the word taken in travel at the same time.
- R3: Each half period of `sclk` lasts DIV+2 system clocks. DIV is in control word 0, bits [7:0]. DIV=0 gives the fastest rate, system clock / 4.
- R4: Control word 1 holds the first entry in bits [4:0] and the last entry in bits [12:8]. The sequencer visits entries in increasing index order modulo 32, from the first entry to the last. `cur_idx` shows the entry being transferred.
- R5: Bits [3:0] of an entry's command word are driven on `pcs` for that entry's whole transfer.
- R6: If command bit [4] (hold) is 0, `pcs` goes back to the idle pattern (control word 2, bits [7:4]) before the next transfer begins. If bit [4] is 1, `pcs` keeps the entry's pattern until the next entry loads. Once the sequencer stops, `pcs` shows the idle pattern.
- R7: The word received during entry *i* appears at `rd_data` when `rd_addr` = *i*.
- R8: When the last entry finishes with wrap off, `done_irq` goes to 1 and `busy` goes to 0. Any write to control word 3 clears `done_irq`.
- R9: If control word 2 bit [1] (wrap) is 1, the sequencer restarts at the first entry after the last one. `busy` stays 1, and `done_irq` is set again after every pass.
- R10: Writing control word 2 with bit [0] = 0 while the sequencer is busy stops it after the entry in progress. At most one more transfer completes, and then `sclk` is 0 and `pcs` shows the idle pattern.
- R11: Write-space code 0 writes transmit memory, code 1 writes command memory and code 2 writes the control words. `wr_addr` picks the entry or the control word. Writing control word 2 with bit [0] = 1 starts the queue when the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_space | input | 2 | Write target: 0 transmit memory, 1 command memory, 2 control words |
| wr_addr | input | 5 | Entry index or control-word number |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Receive memory read index |
| rd_data | output | 16 | Receive memory read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Peripheral-select pattern |
| cur_idx | output | 5 | Index of the entry in progress |
| busy | output | 1 | Sequencer active |
| done_irq | output | 1 | Sticky completion flag and interrupt request |

## Verification
The assertions assume that software leaves the control words and the command entry in use unchanged while a queue runs. The only control write during a run is the halt. The completion check and the select-hold check depend on that. The bench changes every control word only while the sequencer is idle, and it applies a new idle pattern with a separate go=0 write before starting. Its modelled slave changes `miso` only on falling `sclk` edges, which keeps the sampling window that the shift checks rely on.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_STORE,
    ST_GAP
  } seq_st_t;

  typedef struct packed {
    logic             hold;
    logic [SEL_W-1:0] sel;
  } qcmd_t;

  localparam int unsigned CMD_W = $bits(qcmd_t);

endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W:0] cnt_q, cnt_d, reload;

  assign reload = {1'b0, div} + 1'b1;
  assign tick   = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = reload;
    else if (tick) cnt_d = reload;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  half_period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         sample,
  input  logic         shift,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);

  logic [W-1:0] tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load)       tx_d = load_word;
    else if (shift) tx_d = {tx_q[W-2:0], 1'b0};
    if (sample)     rx_d = {rx_q[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = tx_q[W-1];
  assign rx_word = rx_q;

  // R2
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(mosi));

endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned QDEPTH = 32,
  localparam int unsigned IDX_W = $clog2(QDEPTH),
  localparam int unsigned BC_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             halt_req,
  input  logic             wrap,
  input  logic [IDX_W-1:0] first_ptr,
  input  logic [IDX_W-1:0] last_ptr,
  input  logic [SEL_W-1:0] idle_sel,
  input  qcmd_t            cmd,
  input  logic             tick,
  output logic             tmr_en,
  output logic [IDX_W-1:0] idx,
  output logic             load,
  output logic             sample,
  output logic             shift,
  output logic             store,
  output logic             done_set,
  output logic             sclk,
  output logic [SEL_W-1:0] sel,
  output logic             busy
);

  seq_st_t          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_inc;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             sclk_q, sclk_d;
  logic             stop_q, stop_d;
  logic             last_bit, at_end;

  assign last_bit = (bc_q == BC_W'(DATA_W-1));
  assign at_end   = (idx_q == last_ptr);
  assign idx_inc  = (idx_q == IDX_W'(QDEPTH-1)) ? '0 : idx_q + 1'b1;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    sel_d    = sel_q;
    bc_d     = bc_q;
    sclk_d   = sclk_q;
    stop_d   = stop_q;
    load     = 1'b0;
    sample   = 1'b0;
    shift    = 1'b0;
    store    = 1'b0;
    done_set = 1'b0;
    if (halt_req && st_q != ST_IDLE) stop_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        sel_d  = idle_sel;
        sclk_d = 1'b0;
        stop_d = 1'b0;
        if (go_req) begin
          st_d  = ST_LOAD;
          idx_d = first_ptr;
        end
      end
      ST_LOAD: begin
        load  = 1'b1;
        sel_d = cmd.sel;
        bc_d  = '0;
        st_d  = ST_SETUP;
      end
      ST_SETUP, ST_LOW: begin
        if (tick) begin
          sclk_d = 1'b1;
          sample = 1'b1;
          st_d   = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sclk_d = 1'b0;
          if (last_bit) begin
            st_d = ST_STORE;
          end else begin
            shift = 1'b1;
            bc_d  = bc_q + 1'b1;
            st_d  = ST_LOW;
          end
        end
      end
      ST_STORE: begin
        store = 1'b1;
        if (at_end) done_set = 1'b1;
        if (stop_d || (at_end && !wrap)) begin
          st_d   = ST_IDLE;
          sel_d  = idle_sel;
          stop_d = 1'b0;
        end else begin
          idx_d = at_end ? first_ptr : idx_inc;
          if (!cmd.hold) sel_d = idle_sel;
          st_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (stop_d) begin
          st_d   = ST_IDLE;
          sel_d  = idle_sel;
          stop_d = 1'b0;
        end else if (tick) begin
          st_d = ST_LOAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sel_q  <= {SEL_W{1'b1}};
      bc_q   <= '0;
      sclk_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sel_q  <= sel_d;
      bc_q   <= bc_d;
      sclk_q <= sclk_d;
      stop_q <= stop_d;
    end
  end

  assign tmr_en = (st_q == ST_SETUP) || (st_q == ST_HIGH) ||
                  (st_q == ST_LOW)   || (st_q == ST_GAP);
  assign idx    = idx_q;
  assign sclk   = sclk_q;
  assign sel    = sel_q;
  assign busy   = (st_q != ST_IDLE);

  // R3
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk_q));

  // R5
  sel_held_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIGH || st_q == ST_LOW) |=> $stable(sel_q));

  // R4
  idx_moves_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_STORE && st_q != ST_IDLE) |=> $stable(idx_q));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!sclk_q && sel_q == $past(idle_sel)));

endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned QDEPTH = 32,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned IDX_W = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_space,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SEL_W-1:0]  pcs,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              busy,
  output logic              done_irq
);

  localparam int unsigned PTR_HI_LSB = 8;

  logic [DATA_W-1:0] tx_mem [QDEPTH];
  qcmd_t             cmd_mem[QDEPTH];
  logic [DATA_W-1:0] rx_mem [QDEPTH];

  logic [DIV_W-1:0] div_q, div_d;
  logic [IDX_W-1:0] first_q, first_d, last_q, last_d;
  logic             wrap_q, wrap_d;
  logic [SEL_W-1:0] idle_q, idle_d;
  logic             done_q, done_d;

  logic wr_tx, wr_cmd, wr_div, wr_ptr, wr_ctl, wr_clr;
  logic go_req, halt_req;
  logic tick, tmr_en, load, sample, shift, store, done_set;
  logic [DATA_W-1:0] rx_word;
  logic [IDX_W-1:0]  idx;

  assign wr_tx  = wr_en && (wr_space == 2'd0);
  assign wr_cmd = wr_en && (wr_space == 2'd1);
  assign wr_div = wr_en && (wr_space == 2'd2) && (wr_addr == IDX_W'(0));
  assign wr_ptr = wr_en && (wr_space == 2'd2) && (wr_addr == IDX_W'(1));
  assign wr_ctl = wr_en && (wr_space == 2'd2) && (wr_addr == IDX_W'(2));
  assign wr_clr = wr_en && (wr_space == 2'd2) && (wr_addr == IDX_W'(3));

  assign go_req   = wr_ctl &&  wr_data[0];
  assign halt_req = wr_ctl && !wr_data[0];

  always_ff @(posedge clk) begin
    if (wr_tx)  tx_mem[wr_addr]  <= wr_data;
    if (wr_cmd) cmd_mem[wr_addr] <= qcmd_t'(wr_data[CMD_W-1:0]);
    if (store)  rx_mem[idx]      <= rx_word;
  end

  always_comb begin
    div_d   = div_q;
    first_d = first_q;
    last_d  = last_q;
    wrap_d  = wrap_q;
    idle_d  = idle_q;
    done_d  = done_q;
    if (wr_div) div_d = wr_data[DIV_W-1:0];
    if (wr_ptr) begin
      first_d = wr_data[IDX_W-1:0];
      last_d  = wr_data[PTR_HI_LSB +: IDX_W];
    end
    if (wr_ctl) begin
      wrap_d = wr_data[1];
      idle_d = wr_data[4 +: SEL_W];
    end
    if (wr_clr)   done_d = 1'b0;
    if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      wrap_q  <= 1'b0;
      idle_q  <= {SEL_W{1'b1}};
      done_q  <= 1'b0;
    end else begin
      div_q   <= div_d;
      first_q <= first_d;
      last_q  <= last_d;
      wrap_q  <= wrap_d;
      idle_q  <= idle_d;
      done_q  <= done_d;
    end
  end

  qspi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tmr_en),
    .div  (div_q),
    .tick (tick)
  );

  qspi_shift #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_word(tx_mem[idx]),
    .sample   (sample),
    .shift    (shift),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_word)
  );

  qspi_seq #(.DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_req   (go_req),
    .halt_req (halt_req),
    .wrap     (wrap_q),
    .first_ptr(first_q),
    .last_ptr (last_q),
    .idle_sel (idle_q),
    .cmd      (cmd_mem[idx]),
    .tick     (tick),
    .tmr_en   (tmr_en),
    .idx      (idx),
    .load     (load),
    .sample   (sample),
    .shift    (shift),
    .store    (store),
    .done_set (done_set),
    .sclk     (sclk),
    .sel      (pcs),
    .busy     (busy)
  );

  assign rd_data  = rx_mem[rd_addr];
  assign cur_idx  = idx;
  assign done_irq = done_q;

  // R8
  done_at_last_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> ($past(cur_idx) == last_q));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !done_set) |=> !done_irq);

endmodule

// File: tb/qspi_master_tb.sv
module qspi_master_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         idx;
    logic [3:0] sel;
    logic       hold;
    logic [15:0] tx;
  } item_t;

  logic        clk, rst_n;
  logic        wr_en;
  logic [1:0]  wr_space;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;
  logic        sclk, mosi, miso;
  logic [3:0]  pcs;
  logic [4:0]  cur_idx;
  logic        busy, done_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  item_t       sb[$];
  item_t       cur;
  logic [15:0] exp_rx[32];
  int          fallcnt = 0;
  logic [15:0] cap = '0;
  int          seqn = 0;
  bit          prev_hold = 0;
  bit          saw_idle = 1;
  logic [3:0]  idle_exp = 4'hF;
  int          cyc = 0;
  int          last_rise = 0;
  int          exp_period = 4;
  int          words = 0;
  logic [15:0] resp_cur;

  qspi_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_space(wr_space),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .pcs(pcs), .cur_idx(cur_idx),
    .busy(busy), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  assign resp_cur = 16'hC3A0 ^ 16'(seqn * 16'h1357);
  assign miso     = resp_cur[4'(15 - fallcnt)];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (pcs == idle_exp) saw_idle = 1;

  // monitor: pops expected items as transfers start, compares as they end
  always @(posedge sclk) begin
    if (fallcnt == 0) begin
      if (sb.size() == 0) begin
        chk("R4", "unexpected transfer", 1, 0);
      end else begin
        cur = sb.pop_front();
        chk("R4", "cur_idx", 32'(cur_idx), 32'(cur.idx));
        chk("R5", "select pattern", 32'(pcs), 32'(cur.sel));
        chk("R6", "idle seen in gap", 32'(saw_idle), 32'(!prev_hold));
      end
    end else begin
      chk("R3", "sclk period", 32'(cyc - last_rise), 32'(exp_period));
    end
    last_rise = cyc;
    cap = {cap[14:0], mosi};
  end

  always @(negedge sclk) begin
    fallcnt++;
    if (fallcnt == 16) begin
      chk("R2", "mosi word", 32'(cap), 32'(cur.tx));
      exp_rx[cur.idx] = resp_cur;
      fallcnt   = 0;
      seqn++;
      prev_hold = cur.hold;
      saw_idle  = 0;
      words++;
    end
  end

  task automatic wr(input logic [1:0] sp, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_space = sp; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: programs an entry and pushes its expected transfer
  task automatic put(input int i, input logic [3:0] s, input logic h, input logic [15:0] t);
    item_t it;
    wr(2'd0, 5'(i), t);
    wr(2'd1, 5'(i), {11'd0, h, s});
    it.idx = i; it.sel = s; it.hold = h; it.tx = t;
    sb.push_back(it);
  endtask

  task automatic push_only(input int i, input logic [3:0] s, input logic h, input logic [15:0] t);
    item_t it;
    it.idx = i; it.sel = s; it.hold = h; it.tx = t;
    sb.push_back(it);
  endtask

  task automatic wait_until_done();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done_irq) break;
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic chk_rx(string req, input int i);
    @(negedge clk);
    rd_addr = 5'(i);
    #1;
    chk(req, "rx slot", 32'(rd_data), 32'(exp_rx[i]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w0;
    rst_n = 1'b0; wr_en = 1'b0; wr_space = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset sclk", 32'(sclk), 0);
    chk("R1", "reset pcs", 32'(pcs), 32'hF);
    chk("R1", "reset busy", 32'(busy), 0);
    chk("R1", "reset done", 32'(done_irq), 0);

    // test A: fastest clock, entries 0..3, mixed hold bits (R11 programming)
    exp_period = 4;
    wr(2'd2, 5'd0, 16'd0);
    put(0, 4'hE, 1'b1, 16'hA5F0);
    put(1, 4'hD, 1'b0, 16'h1234);
    put(2, 4'hB, 1'b0, 16'h8001);
    put(3, 4'h7, 1'b1, 16'h7FFE);
    wr(2'd2, 5'd1, {3'd0, 5'd3, 3'd0, 5'd0});
    prev_hold = 0; saw_idle = 1;
    wr(2'd2, 5'd2, 16'h00F1);
    wait_until_done();
    @(negedge clk);
    chk("R8", "done after last", 32'(done_irq), 1);
    chk("R8", "busy after last", 32'(busy), 0);
    chk("R6", "pcs idle after stop", 32'(pcs), 32'hF);
    chk("R4", "all entries ran", 32'(words), 4);
    chk("R4", "scoreboard drained", 32'(sb.size()), 0);
    for (int i = 0; i < 4; i++) chk_rx("R7", i);
    wr(2'd2, 5'd3, 16'd0);
    @(negedge clk);
    chk("R8", "done cleared", 32'(done_irq), 0);

    // test B: slower clock, queue straddles index 31 -> 0, idle pattern 0
    exp_period = 10;
    idle_exp = 4'h0;
    wr(2'd2, 5'd0, 16'd3);
    put(30, 4'h9, 1'b0, 16'hDEAD);
    put(31, 4'h6, 1'b1, 16'hBEEF);
    put(0,  4'hC, 1'b0, 16'h0F0F);
    put(1,  4'h3, 1'b0, 16'hF00D);
    wr(2'd2, 5'd1, {3'd0, 5'd1, 3'd0, 5'd30});
    wr(2'd2, 5'd2, 16'h0000);
    prev_hold = 0; saw_idle = 1; w0 = words;
    wr(2'd2, 5'd2, 16'h0001);
    wait_until_done();
    @(negedge clk);
    chk("R4", "wrapped index run", 32'(words - w0), 4);
    chk("R8", "busy low B", 32'(busy), 0);
    chk("R6", "pcs idle 0", 32'(pcs), 32'h0);
    chk_rx("R7", 30); chk_rx("R7", 31); chk_rx("R7", 0); chk_rx("R7", 1);
    wr(2'd2, 5'd3, 16'd0);

    // test C: wrap mode on entries 5..6, then halt
    exp_period = 6;
    wr(2'd2, 5'd0, 16'd1);
    put(5, 4'h3, 1'b0, 16'h5A5A);
    put(6, 4'h5, 1'b1, 16'h0001);
    for (int p = 0; p < 9; p++) begin
      push_only(5, 4'h3, 1'b0, 16'h5A5A);
      push_only(6, 4'h5, 1'b1, 16'h0001);
    end
    wr(2'd2, 5'd1, {3'd0, 5'd6, 3'd0, 5'd5});
    prev_hold = 0; saw_idle = 1; w0 = words;
    wr(2'd2, 5'd2, 16'h0003);
    wait_until_done();
    @(negedge clk);
    chk("R9", "busy after pass", 32'(busy), 1);
    wr(2'd2, 5'd3, 16'd0);
    wait_until_done();
    @(negedge clk);
    chk("R9", "done again on next pass", 32'(done_irq), 1);
    chk("R9", "still busy", 32'(busy), 1);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (words - w0 >= 6) break;
    end
    w0 = words;
    wr(2'd2, 5'd2, 16'h0002);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R10", "at most one more transfer", 32'(words - w0 <= 1), 1);
    chk("R10", "stopped", 32'(busy), 0);
    chk("R10", "sclk low", 32'(sclk), 0);
    chk("R10", "pcs idle", 32'(pcs), 32'h0);
    sb.delete();
    chk_rx("R7", 5); chk_rx("R7", 6);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule